// File: doc/BRIEF.md
# Compact-ISA Branch and Link Sequencer

This block resolves the control-flow instructions of a 16-bit compact instruction set: the conditional branch, the unconditional branch, and the long branch-with-link. The long branch-with-link is split over two halfwords. The decode stage hands the block one halfword per accepted cycle, together with that halfword's own address, the N/Z/C/V flags, the current link register value and a v5 feature enable. One clock later the block presents its result:

- whether a branch is taken, and its target;
- a single-cycle pipeline flush;
- an optional link-register write with its data;
- a request to switch to the wide-ISA state;
- a software-interrupt indication with its 8-bit number, or an undefined-instruction indication.

The first halfword of a long branch leaves a partial address in the link register. The second halfword adds its own offset to that value. The register file sits outside the block, so a write made by the first halfword is not yet visible on `link_in` when the second halfword follows at once. For that reason the block keeps its own copy of the partial address. It uses that copy in place of `link_in` when the next accepted halfword completes the pair.

Top module: `cflow_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs `taken`, `flush`, `link_wr`, `to_wide`, `swi` and `undef` are all low.
- R2: Instruction bits [15:12]=1101 with condition field [11:8] below 14 form a conditional branch. The condition codes are 0 Z, 1 not Z, 2 C, 3 not C, 4 N, 5 not N, 6 V, 7 not V, 8 C and not Z, 9 not C or Z, 10 N==V, 11 N!=V, 12 not Z and N==V, 13 Z or N!=V, where `flags`={N,Z,C,V} from bit 3 down to bit 0. When the condition passes, `taken` and `flush` rise and `target` = pc + 4 + (sign-extended bits [7:0] << 1).
- R3: A failing condition leaves `taken`, `flush` and `to_wide` low. No conditional or unconditional branch ever raises `link_wr`.
- R4: In the conditional-branch format, condition field 15 raises `swi` with `swi_imm` = bits [7:0]. Condition field 14 raises `undef`. Neither raises `taken`.
- R5: Bits [15:11]=28 is an unconditional branch: `taken` and `flush` rise and `target` = pc + 4 + (bits [10:0] sign-extended from bit 10, << 1).
- R6: Bits [15:11]=30 (first half) raises `link_wr` with `link_wdata` = pc + (bits [10:0] sign-extended from bit 10, << 12). It does not raise `taken` or `flush`.
- R7: Bits [15:11]=31 (second half) raises `taken`, `flush` and `link_wr`. It sets `target` = link + (bits [10:0] << 1) and `link_wdata` = (pc + 2) with bit 0 set.
- R8: Bits [15:11]=29 with `v5_en` high and bit 0 clear behaves like R7, except that `target` has its two low bits cleared and `to_wide` rises.
- R9: Bits [15:11]=29 with bit 0 set, or with `v5_en` low, raises only `undef`. There is no branch and no link write.
- R10: When the accepted halfword just before a second half (class 29 or 31) was a first half, the link value used is the one that first half produced, and `link_in` is ignored. Idle cycles in between do not break the pairing, but any other accepted halfword does.
- R11: A second half with no first half just before it uses `link_in`.
- R12: Every output strobe is a pulse for the halfword accepted on the previous edge. With `instr_valid` low, or for a halfword outside the classes above, every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | A halfword is presented this cycle |
| instr | input | 16 | Compact instruction halfword |
| pc | input | ADDR_W | Address of this halfword |
| flags | input | 4 | {N,Z,C,V} |
| link_in | input | ADDR_W | Current link register value |
| v5_en | input | 1 | Enables the state-switching second half |
| taken | output | 1 | Branch taken |
| flush | output | 1 | One-cycle pipeline flush |
| target | output | ADDR_W | Branch target |
| link_wr | output | 1 | Link register write enable |
| link_wdata | output | ADDR_W | Link register write data |
| to_wide | output | 1 | Switch to wide-ISA state requested |
| swi | output | 1 | Software interrupt |
| swi_imm | output | 8 | Software interrupt number |
| undef | output | 1 | Undefined instruction |

## Verification
Two functions can meet in the same cycle: the first half's link write leaving the block, and the second half arriving and reading the link. The bench provokes this by issuing the second half on the edge right after the first, while `link_in` still carries a stale value. The result is judged correct only if `target` is built from the first half's partial address. Variants are then checked: an idle gap inside the pair must keep the pairing, and an unrelated halfword inside the pair must break it, so that `link_in` is used again.

// File: rtl/cflow_pkg.sv
// Package: shared encodings for the compact-ISA branch sequencer.
// Assumes the instruction class is bits [15:11] of a halfword.
package cflow_pkg;

    localparam logic [4:0] CLS_SEC_WIDE = 5'd29;
    localparam logic [4:0] CLS_FIRST    = 5'd30;
    localparam logic [4:0] CLS_SEC      = 5'd31;
    localparam logic [4:0] CLS_JUMP     = 5'd28;
    localparam logic [3:0] CONDBR_TOP   = 4'b1101;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0, CC_NE, CC_CS, CC_CC, CC_MI, CC_PL, CC_VS, CC_VC,
        CC_HI, CC_LS, CC_GE, CC_LT, CC_GT, CC_LE, CC_RSV, CC_TRAP
    } cc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        logic taken;
        logic link_wr;
        logic to_wide;
        logic swi;
        logic undef;
        logic first;
    } ctl_t;

endpackage

// File: rtl/cflow_cond_eval.sv
// Condition evaluator: returns whether a 4-bit condition code passes for
// the given flags. Codes 14 and 15 never pass (they are decoded elsewhere).
module cflow_cond_eval
    import cflow_pkg::*;
(
    input  cc_e   cc,
    input  nzcv_t fl,
    output logic  pass
);

    // Purpose: map each condition code onto its flag expression.
    always_comb begin
        case (cc)
            CC_EQ:   pass = fl.z;
            CC_NE:   pass = !fl.z;
            CC_CS:   pass = fl.c;
            CC_CC:   pass = !fl.c;
            CC_MI:   pass = fl.n;
            CC_PL:   pass = !fl.n;
            CC_VS:   pass = fl.v;
            CC_VC:   pass = !fl.v;
            CC_HI:   pass = fl.c && !fl.z;
            CC_LS:   pass = !fl.c || fl.z;
            CC_GE:   pass = (fl.n == fl.v);
            CC_LT:   pass = (fl.n != fl.v);
            CC_GT:   pass = !fl.z && (fl.n == fl.v);
            CC_LE:   pass = fl.z || (fl.n != fl.v);
            default: pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/cflow_decode.sv
// Branch decoder: classifies one halfword and computes the target, link data
// and control strobes. Assumes link_eff already carries any pending first-half
// value and cond_pass comes from the condition evaluator.
module cflow_decode
    import cflow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [15:0]       instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] link_eff,
    input  logic              cond_pass,
    input  logic              v5_en,
    output ctl_t              ctl,
    output logic [ADDR_W-1:0] tgt,
    output logic [ADDR_W-1:0] lnk
);

    localparam int PAD8  = ADDR_W - 9;
    localparam int PAD11 = ADDR_W - 12;
    localparam int PADHI = ADDR_W - 23;

    logic [4:0]        cls;
    cc_e               cc;
    logic [ADDR_W-1:0] off8_sx, off11_sx, off_hi, off_lo;
    logic [ADDR_W-1:0] pc_plus4, ret_addr, sec_sum;

    // Purpose: slice fields and form the offsets and base addresses.
    always_comb begin
        cls      = instr[15:11];
        cc       = cc_e'(instr[11:8]);
        off8_sx  = {{PAD8{instr[7]}}, instr[7:0], 1'b0};
        off11_sx = {{PAD11{instr[10]}}, instr[10:0], 1'b0};
        off_hi   = {{PADHI{instr[10]}}, instr[10:0], 12'd0};
        off_lo   = {{PAD11{1'b0}}, instr[10:0], 1'b0};
        pc_plus4 = pc + ADDR_W'(4);
        ret_addr = pc + ADDR_W'(2);
        ret_addr[0] = 1'b1;
        sec_sum  = link_eff + off_lo;
    end

    // Purpose: select the result for the instruction class.
    always_comb begin
        ctl = '0;
        tgt = '0;
        lnk = '0;
        if (instr[15:12] == CONDBR_TOP) begin
            if (cc == CC_TRAP) begin
                ctl.swi = 1'b1;
            end else if (cc == CC_RSV) begin
                ctl.undef = 1'b1;
            end else begin
                ctl.taken = cond_pass;
                tgt       = pc_plus4 + off8_sx;
            end
        end else begin
            case (cls)
                CLS_JUMP: begin
                    ctl.taken = 1'b1;
                    tgt       = pc_plus4 + off11_sx;
                end
                CLS_SEC_WIDE: begin
                    if (v5_en && !instr[0]) begin
                        ctl.taken   = 1'b1;
                        ctl.link_wr = 1'b1;
                        ctl.to_wide = 1'b1;
                        tgt         = {sec_sum[ADDR_W-1:2], 2'b00};
                        lnk         = ret_addr;
                    end else begin
                        ctl.undef = 1'b1;
                    end
                end
                CLS_FIRST: begin
                    ctl.link_wr = 1'b1;
                    ctl.first   = 1'b1;
                    lnk         = pc + off_hi;
                end
                CLS_SEC: begin
                    ctl.taken   = 1'b1;
                    ctl.link_wr = 1'b1;
                    tgt         = sec_sum;
                    lnk         = ret_addr;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cflow_seq.sv
// Top: branch and link sequencer. It registers the decoded result one cycle
// after an accepted halfword and keeps the last first-half link value so
// that an immediately following second half does not depend on the
// register file write having landed. Assumes ADDR_W >= 24.
module cflow_seq
    import cflow_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [15:0]       instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [3:0]        flags,
    input  logic [ADDR_W-1:0] link_in,
    input  logic              v5_en,
    output logic              taken,
    output logic              flush,
    output logic [ADDR_W-1:0] target,
    output logic              link_wr,
    output logic [ADDR_W-1:0] link_wdata,
    output logic              to_wide,
    output logic              swi,
    output logic [7:0]        swi_imm,
    output logic              undef
);

    logic              pend_q;
    logic [ADDR_W-1:0] pend_link_q;
    logic [ADDR_W-1:0] link_eff;
    logic              pass;
    ctl_t              ctl;
    logic [ADDR_W-1:0] tgt, lnk;

    // Purpose: pick the pending first-half value over the register file copy.
    always_comb link_eff = pend_q ? pend_link_q : link_in;

    cflow_cond_eval u_cond (
        .cc   (cc_e'(instr[11:8])),
        .fl   (nzcv_t'(flags)),
        .pass (pass)
    );

    cflow_decode #(.ADDR_W(ADDR_W)) u_dec (
        .instr     (instr),
        .pc        (pc),
        .link_eff  (link_eff),
        .cond_pass (pass),
        .v5_en     (v5_en),
        .ctl       (ctl),
        .tgt       (tgt),
        .lnk       (lnk)
    );

    // Purpose: track whether the last accepted halfword was a first half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_link_q <= '0;
        end else if (instr_valid) begin
            pend_q <= ctl.first;
            if (ctl.first) pend_link_q <= lnk;
        end
    end

    // Purpose: register the result as single-cycle strobes plus data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            flush      <= 1'b0;
            link_wr    <= 1'b0;
            to_wide    <= 1'b0;
            swi        <= 1'b0;
            undef      <= 1'b0;
            target     <= '0;
            link_wdata <= '0;
            swi_imm    <= '0;
        end else if (instr_valid) begin
            taken      <= ctl.taken;
            flush      <= ctl.taken;
            link_wr    <= ctl.link_wr;
            to_wide    <= ctl.to_wide;
            swi        <= ctl.swi;
            undef      <= ctl.undef;
            target     <= tgt;
            link_wdata <= lnk;
            swi_imm    <= instr[7:0];
        end else begin
            taken   <= 1'b0;
            flush   <= 1'b0;
            link_wr <= 1'b0;
            to_wide <= 1'b0;
            swi     <= 1'b0;
            undef   <= 1'b0;
        end
    end

endmodule

// File: rtl/cflow_seq_chk.sv
// Checker: temporal properties of the branch sequencer, bound to cflow_seq.
module cflow_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [15:0]       instr,
    input logic              v5_en,
    input logic              taken,
    input logic              flush,
    input logic [ADDR_W-1:0] target,
    input logic              link_wr,
    input logic [ADDR_W-1:0] link_wdata,
    input logic              to_wide,
    input logic              swi,
    input logic [7:0]        swi_imm,
    input logic              undef
);

    p_branch_nolink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (instr[15:12] == 4'b1101 || instr[15:11] == 5'd28)
        |=> !link_wr);

    p_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr[15:12] == 4'b1101 && instr[11:8] == 4'hF
        |=> swi && !taken && swi_imm == $past(instr[7:0]));

    p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr[15:11] == 5'd28 |=> taken && flush);

    p_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr[15:11] == 5'd30 |=> link_wr && !taken && !flush);

    p_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr[15:11] == 5'd31 |=> taken && link_wr && link_wdata[0]);

    p_wide_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        to_wide |-> taken && target[1:0] == 2'b00);

    p_wide_bad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr[15:11] == 5'd29 && (instr[0] || !v5_en)
        |=> undef && !taken && !link_wr);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !taken && !flush && !link_wr && !swi && !undef && !to_wide);

endmodule

bind cflow_seq cflow_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .v5_en       (v5_en),
    .taken       (taken),
    .flush       (flush),
    .target      (target),
    .link_wr     (link_wr),
    .link_wdata  (link_wdata),
    .to_wide     (to_wide),
    .swi         (swi),
    .swi_imm     (swi_imm),
    .undef       (undef)
);

// File: tb/cflow_seq_tb_top.sv
// Directed bench for cflow_seq: one task per scenario, each checking itself.
module cflow_seq_tb_top;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [15:0]   instr = '0;
    logic [W-1:0]  pc = '0;
    logic [3:0]    flags = '0;
    logic [W-1:0]  link_in = '0;
    logic          v5_en = 1'b0;
    logic          taken, flush, link_wr, to_wide, swi, undef;
    logic [W-1:0]  target, link_wdata;
    logic [7:0]    swi_imm;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cflow_seq #(.ADDR_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .pc(pc), .flags(flags), .link_in(link_in), .v5_en(v5_en),
        .taken(taken), .flush(flush), .target(target), .link_wr(link_wr),
        .link_wdata(link_wdata), .to_wide(to_wide), .swi(swi),
        .swi_imm(swi_imm), .undef(undef)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // strobes as {taken, flush, link_wr, to_wide, swi, undef}
    task automatic chk_strb(input string req, input logic [5:0] exp);
        chk(req, "strobes", {26'd0, taken, flush, link_wr, to_wide, swi, undef}, {26'd0, exp});
    endtask

    task automatic send(input logic [15:0] ins, input logic [W-1:0] p,
                        input logic [W-1:0] lk, input logic [3:0] f, input logic v5);
        @(negedge clk);
        instr = ins; pc = p; link_in = lk; flags = f; v5_en = v5; instr_valid = 1'b1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        instr_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    function automatic logic cond_ref(input int c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && n == v;
            default: return z || n != v;
        endcase
    endfunction

    function automatic logic [W-1:0] sx11(input logic [10:0] o);
        return {{21{o[10]}}, o};
    endfunction

    task automatic t_reset();
        chk_strb("R1", 6'b000000);
    endtask

    task automatic t_cond_table();
        for (int c = 0; c < 14; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic p;
                p = cond_ref(c, 4'(f));
                send({4'b1101, 4'(c), 8'h10}, 32'h0000_4000, 32'h0, 4'(f), 1'b0);
                if (p) begin
                    chk_strb("R2", 6'b110000);
                    chk("R2", "target", target, 32'h0000_4000 + 4 + 32'h20);
                end else begin
                    chk_strb("R3", 6'b000000);
                end
            end
        end
    endtask

    task automatic t_cond_offsets();
        send({4'b1101, 4'd0, 8'h80}, 32'h0000_1000, 32'h0, 4'b0100, 1'b0);
        chk("R2", "neg target", target, 32'h0000_1004 - 32'd256);
        send({4'b1101, 4'd1, 8'h7F}, 32'h0000_2000, 32'h0, 4'b0000, 1'b0);
        chk("R2", "pos target", target, 32'h0000_2004 + 32'd254);
        send({4'b1101, 4'd0, 8'hFF}, 32'h0000_0000, 32'h0, 4'b0100, 1'b0);
        chk("R2", "wrap target", target, 32'h0000_0002);
    endtask

    task automatic t_trap_undef();
        send({4'b1101, 4'hF, 8'hAB}, 32'h100, 32'h0, 4'hF, 1'b1);
        chk_strb("R4", 6'b000010);
        chk("R4", "swi_imm", {24'd0, swi_imm}, 32'hAB);
        send({4'b1101, 4'hE, 8'h12}, 32'h100, 32'h0, 4'hF, 1'b1);
        chk_strb("R4", 6'b000001);
    endtask

    task automatic t_jump();
        send({5'd28, 11'h155}, 32'h0000_3000, 32'h0, 4'h0, 1'b0);
        chk_strb("R5", 6'b110000);
        chk("R5", "pos target", target, 32'h0000_3004 + (sx11(11'h155) << 1));
        send({5'd28, 11'h600}, 32'h0000_3000, 32'h0, 4'h0, 1'b0);
        chk("R5", "neg target", target, 32'h0000_3004 + (sx11(11'h600) << 1));
    endtask

    task automatic t_first();
        send({5'd30, 11'h005}, 32'h0000_1000, 32'hDEAD_0000, 4'h0, 1'b0);
        chk_strb("R6", 6'b001000);
        chk("R6", "link pos", link_wdata, 32'h0000_1000 + (sx11(11'h005) << 12));
        send({5'd30, 11'h7FF}, 32'h0000_8000, 32'h0, 4'h0, 1'b0);
        chk("R6", "link neg", link_wdata, 32'h0000_8000 + (sx11(11'h7FF) << 12));
        idle();
    endtask

    task automatic t_second_lone();
        send(16'h0000, 32'h0, 32'h0, 4'h0, 1'b0);
        send({5'd31, 11'h010}, 32'h0000_0500, 32'h0004_0000, 4'h0, 1'b0);
        chk_strb("R11", 6'b111000);
        chk("R11", "target", target, 32'h0004_0000 + 32'h20);
        chk("R7", "link", link_wdata, 32'h0000_0503);
    endtask

    task automatic t_pairs();
        logic [W-1:0] part;
        part = 32'h0000_1000 + (sx11(11'h005) << 12);
        send({5'd30, 11'h005}, 32'h0000_1000, 32'hDEAD_0000, 4'h0, 1'b0);
        send({5'd31, 11'h010}, 32'h0000_1002, 32'hDEAD_0000, 4'h0, 1'b0);
        chk("R10", "back-to-back target", target, part + 32'h20);
        chk("R7", "link", link_wdata, 32'h0000_1005);
        send({5'd30, 11'h005}, 32'h0000_1000, 32'hDEAD_0000, 4'h0, 1'b1);
        idle();
        send({5'd29, 11'h012}, 32'h0000_1002, 32'hDEAD_0000, 4'h0, 1'b1);
        chk("R10", "gap wide target", target, (part + 32'h24) & ~32'h3);
        chk_strb("R8", 6'b111100);
        send({5'd30, 11'h005}, 32'h0000_1000, 32'hDEAD_0000, 4'h0, 1'b0);
        send(16'h0000, 32'h0000_1002, 32'hDEAD_0000, 4'h0, 1'b0);
        chk_strb("R12", 6'b000000);
        send({5'd31, 11'h010}, 32'h0000_1004, 32'h0000_7000, 4'h0, 1'b0);
        chk("R10", "broken pair uses link_in", target, 32'h0000_7020);
    endtask

    task automatic t_wide();
        send(16'h0000, 32'h0, 32'h0, 4'h0, 1'b1);
        send({5'd29, 11'h002}, 32'h0000_0600, 32'h0000_2002, 4'h0, 1'b1);
        chk_strb("R8", 6'b111100);
        chk("R8", "target", target, 32'h0000_2004);
        chk("R8", "link", link_wdata, 32'h0000_0603);
    endtask

    task automatic t_wide_bad();
        send({5'd29, 11'h003}, 32'h0000_0600, 32'h0000_2002, 4'h0, 1'b1);
        chk_strb("R9", 6'b000001);
        send({5'd29, 11'h002}, 32'h0000_0600, 32'h0000_2002, 4'h0, 1'b0);
        chk_strb("R9", 6'b000001);
    endtask

    task automatic t_quiet();
        send({5'd28, 11'h001}, 32'h0, 32'h0, 4'h0, 1'b0);
        idle();
        chk_strb("R12", 6'b000000);
        send(16'h4A5C, 32'h0, 32'h0, 4'hF, 1'b1);
        chk_strb("R12", 6'b000000);
        send({5'd30, 11'h001}, 32'h0, 32'h0, 4'h0, 1'b0);
        idle();
        chk_strb("R12", 6'b000000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_cond_table();
        t_cond_offsets();
        t_trap_undef();
        t_jump();
        t_first();
        t_second_lone();
        t_pairs();
        t_wide();
        t_wide_bad();
        t_quiet();
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule